// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block sequences a processor's accesses to memory and peripherals over a bus whose low 16 lines carry the address first and the data afterwards, while 8 further lines carry the upper address bits for the whole access. A requester hands over one access at a time: a 24-bit address, a direction, a flag saying whether the upper data byte takes part, write data and a 4-bit code telling why the access happens. The controller walks the access through four fixed phases (address, turn-around, data, completion), stretching the data phase while a slow target holds the wait input, and hands back read data at the end.

Outside the phases it also drives the strobe and latch-enable pair that an external latch uses to catch the low address bits, the direction and upper-byte flags, and a 4-bit status that reports either the reason for the current access or, between accesses, the kind of idle the processor is in. Back-to-back accesses run with no idle clock between them.

Top module: `mbus_seq`

## Requirements
- R1: After reset the controller is idle: `addr_stb_n`=1, `latch_en`=1, `bus_ad_oe`=0, `done`=0, `xfer_rd`=0, `hi_byte_n`=1, `bus_a_hi`=0 and `rd_data`=0.
- R2: In the first clock after a request is accepted (phase T1) `addr_stb_n` and `latch_en` are both 0 for exactly that one clock, `bus_ad_out` carries address bits 15:0 with `bus_ad_oe`=1, and `bus_a_hi` carries address bits 23:16.
- R3: From T1 through T4 (wait states included) `xfer_rd` is 1 for a read and 0 for a write, and `hi_byte_n` is 0 exactly when the request asked for the upper byte.
- R4: From T2 through T4 a read leaves `bus_ad_oe`=0, a write drives `bus_ad_out`=write data with `bus_ad_oe`=1, and `bus_a_hi` stays at the T1 value.
- R5: With `bus_wait` low an access takes exactly four clocks T1, T2, T3, T4, and `done` is 1 only in T4, for one clock.
- R6: `bus_wait` is sampled at the end of T3 and of every wait state; each clock it is high inserts one wait state, so `done` rises in clock 4+N of the access for N wait clocks.
- R7: For a read, `rd_data` takes the value on `bus_ad_in` at the clock edge that ends T4 and holds it; a write leaves `rd_data` unchanged.
- R8: During an access `cyc_status` equals the request's 4-bit reason code, bit 0 least significant (for example 1000 sequential fetch, 0100 master interrupt acknowledge, 1010 data transfer).
- R9: A write whose reason code is 1011 (read-modify-write operand) reports 1010 instead; a read with code 1011 reports 1011.
- R10: While idle `cyc_status` shows `idle_code` when it is 0000 (no access needed), 0001 (waiting in a halt instruction) or 0011 (waiting on a coprocessor), and 0000 for any other `idle_code` value.
- R11: `req_ready` is 1 only in idle and in T4; a request present in T4 starts T1 in the very next clock, and a request raised while `req_ready` is 0 has no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request taken at this edge when high |
| req_addr | input | 24 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hibyte | input | 1 | Upper data byte takes part |
| req_wdata | input | 16 | Write data |
| req_reason | input | 4 | Reason code reported on the status lines |
| idle_code | input | 4 | Idle kind reported between accesses |
| bus_wait | input | 1 | Target asks for another wait state |
| bus_ad_in | input | 16 | Shared lines as read from the bus |
| bus_ad_out | output | 16 | Value driven onto the shared lines |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_a_hi | output | 8 | Upper address lines |
| addr_stb_n | output | 1 | Active-low address strobe, low in T1 |
| latch_en | output | 1 | Address latch enable, low in T1 |
| xfer_rd | output | 1 | Direction flag, 1 during a read access |
| hi_byte_n | output | 1 | Active-low upper-byte enable |
| cyc_status | output | 4 | Cycle reason or idle kind |
| rd_data | output | 16 | Last read data |
| done | output | 1 | Access completes at the end of this clock |

## Verification
A request held at an edge where `req_ready` is high shows its T1 outputs in the next clock, T2 and T3 in the two clocks after, then one clock per wait state, and `done` in clock 4+N; `rd_data` changes only at the edge that closes T4, so it is checked from the following clock (the next T1 when accesses are chained). The bench drives every input on the falling edge and samples on the falling edge one clock later, walking the access phase by phase, so each check lands in the clock the requirement names. Idle status and ignored requests are checked at the ports between edges, before the next stimulus.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   localparam int ST_W = 4;

   typedef logic [ST_W-1:0] st_code_t;

   // idle kinds that may appear on the status lines between accesses
   localparam st_code_t ST_IDLE_NONE  = 4'b0000;
   localparam st_code_t ST_IDLE_HALT  = 4'b0001;
   localparam st_code_t ST_IDLE_COPRO = 4'b0011;
   // access codes with special handling
   localparam st_code_t ST_DATA_XFER  = 4'b1010;
   localparam st_code_t ST_RMW_READ   = 4'b1011;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_TW   = 3'd4,
      PH_T4   = 3'd5
   } phase_e;

endpackage

// File: rtl/mbus_phase.sv
module mbus_phase
   import mbus_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   bus_wait,
   output phase_e ph,
   output logic   req_ready,
   output logic   accept,
   output logic   done
);

   phase_e ph_q;
   phase_e ph_d;

   always_comb begin
      req_ready = (ph_q == PH_IDLE) || (ph_q == PH_T4);
      accept    = req_ready && req_valid;
      done      = (ph_q == PH_T4);
   end

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE: ph_d = accept ? PH_T1 : PH_IDLE;
         PH_T1:   ph_d = PH_T2;
         PH_T2:   ph_d = PH_T3;
         PH_T3:   ph_d = bus_wait ? PH_TW : PH_T4;
         PH_TW:   ph_d = bus_wait ? PH_TW : PH_T4;
         PH_T4:   ph_d = accept ? PH_T1 : PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign ph = ph_q;

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
   import mbus_pkg::*;
#(
   parameter int ADDR_W         = 24,
   parameter int DATA_W         = 16,
   parameter bit IDLE_ADDR_HOLD = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     accept,
   input  phase_e                   ph,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic                     req_write,
   input  logic                     req_hibyte,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic [DATA_W-1:0]        bus_ad_in,
   output logic [DATA_W-1:0]        bus_ad_out,
   output logic                     bus_ad_oe,
   output logic [ADDR_W-DATA_W-1:0] bus_a_hi,
   output logic                     addr_stb_n,
   output logic                     latch_en,
   output logic                     xfer_rd,
   output logic                     hi_byte_n,
   output logic [DATA_W-1:0]        rd_data
);

   localparam int HI_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] cur_addr;
   logic              cur_wr;
   logic              cur_hb;
   logic [DATA_W-1:0] cur_wd;
   logic              in_cyc;
   logic              addr_ph;
   logic              data_ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         cur_wr   <= 1'b0;
         cur_hb   <= 1'b0;
         cur_wd   <= '0;
      end else if (accept) begin
         cur_addr <= req_addr;
         cur_wr   <= req_write;
         cur_hb   <= req_hibyte;
         cur_wd   <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rd_data <= '0;
      else if (ph == PH_T4 && !cur_wr) rd_data <= bus_ad_in;
   end

   always_comb begin
      in_cyc  = (ph != PH_IDLE);
      addr_ph = (ph == PH_T1);
      data_ph = in_cyc && !addr_ph;
   end

   always_comb begin
      addr_stb_n = !addr_ph;
      latch_en   = !addr_ph;
      xfer_rd    = in_cyc && !cur_wr;
      hi_byte_n  = !(in_cyc && cur_hb);
      bus_ad_out = addr_ph ? cur_addr[DATA_W-1:0] : cur_wd;
      bus_ad_oe  = addr_ph || (data_ph && cur_wr);
   end

   generate
      if (IDLE_ADDR_HOLD) begin : g_hold
         assign bus_a_hi = cur_addr[ADDR_W-1 -: HI_W];
      end else begin : g_park
         assign bus_a_hi = in_cyc ? cur_addr[ADDR_W-1 -: HI_W] : '0;
      end
   endgenerate

endmodule

// File: rtl/mbus_status.sv
module mbus_status
   import mbus_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     accept,
   input  phase_e   ph,
   input  st_code_t req_reason,
   input  logic     req_write,
   input  st_code_t idle_code,
   output st_code_t cyc_status
);

   st_code_t cur_code;
   st_code_t idle_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_code <= ST_IDLE_NONE;
      end else if (accept) begin
         cur_code <= (req_write && req_reason == ST_RMW_READ) ? ST_DATA_XFER
                                                              : req_reason;
      end
   end

   always_comb begin
      unique case (idle_code)
         ST_IDLE_NONE, ST_IDLE_HALT, ST_IDLE_COPRO: idle_f = idle_code;
         default:                                   idle_f = ST_IDLE_NONE;
      endcase
   end

   assign cyc_status = (ph == PH_IDLE) ? idle_f : cur_code;

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
   import mbus_pkg::*;
#(
   parameter int ADDR_W         = 24,
   parameter int DATA_W         = 16,
   parameter bit IDLE_ADDR_HOLD = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic                     req_write,
   input  logic                     req_hibyte,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic [ST_W-1:0]          req_reason,
   input  logic [ST_W-1:0]          idle_code,
   input  logic                     bus_wait,
   input  logic [DATA_W-1:0]        bus_ad_in,
   output logic [DATA_W-1:0]        bus_ad_out,
   output logic                     bus_ad_oe,
   output logic [ADDR_W-DATA_W-1:0] bus_a_hi,
   output logic                     addr_stb_n,
   output logic                     latch_en,
   output logic                     xfer_rd,
   output logic                     hi_byte_n,
   output logic [ST_W-1:0]          cyc_status,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     done
);

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("mbus_seq: DATA_W must be a whole number of bytes");
      end
      if (ADDR_W <= DATA_W) begin : g_bad_addr
         $error("mbus_seq: ADDR_W must exceed DATA_W");
      end
   endgenerate

   phase_e ph;
   logic   accept;

   mbus_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .bus_wait  (bus_wait),
      .ph        (ph),
      .req_ready (req_ready),
      .accept    (accept),
      .done      (done)
   );

   mbus_datapath #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .IDLE_ADDR_HOLD (IDLE_ADDR_HOLD)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .ph         (ph),
      .req_addr   (req_addr),
      .req_write  (req_write),
      .req_hibyte (req_hibyte),
      .req_wdata  (req_wdata),
      .bus_ad_in  (bus_ad_in),
      .bus_ad_out (bus_ad_out),
      .bus_ad_oe  (bus_ad_oe),
      .bus_a_hi   (bus_a_hi),
      .addr_stb_n (addr_stb_n),
      .latch_en   (latch_en),
      .xfer_rd    (xfer_rd),
      .hi_byte_n  (hi_byte_n),
      .rd_data    (rd_data)
   );

   mbus_status u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .ph         (ph),
      .req_reason (req_reason),
      .req_write  (req_write),
      .idle_code  (idle_code),
      .cyc_status (cyc_status)
   );

endmodule

// File: rtl/mbus_chk.sv
module mbus_chk
   import mbus_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input phase_e                   ph,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic                     bus_wait,
   input logic                     bus_ad_oe,
   input logic [ADDR_W-DATA_W-1:0] bus_a_hi,
   input logic                     addr_stb_n,
   input logic                     latch_en,
   input logic                     xfer_rd,
   input logic [ST_W-1:0]          cyc_status,
   input logic                     done
);

   assert_t1_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_T1) |-> (!addr_stb_n && !latch_en && bus_ad_oe));

   assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_stb_n |=> addr_stb_n);

   assert_upper_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_T2 || ph == PH_T3 || ph == PH_TW || ph == PH_T4) |-> $stable(bus_a_hi));

   assert_read_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE && ph != PH_T1 && xfer_rd) |-> !bus_ad_oe);

   assert_no_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph == PH_T3 || ph == PH_TW) && !bus_wait) |=> (ph == PH_T4 && done));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_wait_insert_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph == PH_T3 || ph == PH_TW) && bus_wait) |=> (ph == PH_TW && !done));

   assert_rmw_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE && !xfer_rd) |-> (cyc_status != ST_RMW_READ));

   assert_idle_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |-> (cyc_status == ST_IDLE_NONE || cyc_status == ST_IDLE_HALT ||
                           cyc_status == ST_IDLE_COPRO));

   assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (ph == PH_T1));

   assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> addr_stb_n);

endmodule

bind mbus_seq mbus_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ph         (ph),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .bus_wait   (bus_wait),
   .bus_ad_oe  (bus_ad_oe),
   .bus_a_hi   (bus_a_hi),
   .addr_stb_n (addr_stb_n),
   .latch_en   (latch_en),
   .xfer_rd    (xfer_rd),
   .cyc_status (cyc_status),
   .done       (done)
);

// File: tb/sim_mbus_seq.sv
module sim_mbus_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_hibyte = 1'b0;
   logic [15:0] req_wdata = '0;
   logic [3:0]  req_reason = '0;
   logic [3:0]  idle_code = '0;
   logic        bus_wait = 1'b0;
   logic [15:0] bus_ad_in = '0;
   logic [15:0] bus_ad_out;
   logic        bus_ad_oe;
   logic [7:0]  bus_a_hi;
   logic        addr_stb_n;
   logic        latch_en;
   logic        xfer_rd;
   logic        hi_byte_n;
   logic [3:0]  cyc_status;
   logic [15:0] rd_data;
   logic        done;

   int          total = 0;
   int          bad = 0;
   logic [15:0] exp_rd = '0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   mbus_seq u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_write  (req_write),
      .req_hibyte (req_hibyte),
      .req_wdata  (req_wdata),
      .req_reason (req_reason),
      .idle_code  (idle_code),
      .bus_wait   (bus_wait),
      .bus_ad_in  (bus_ad_in),
      .bus_ad_out (bus_ad_out),
      .bus_ad_oe  (bus_ad_oe),
      .bus_a_hi   (bus_a_hi),
      .addr_stb_n (addr_stb_n),
      .latch_en   (latch_en),
      .xfer_rd    (xfer_rd),
      .hi_byte_n  (hi_byte_n),
      .cyc_status (cyc_status),
      .rd_data    (rd_data),
      .done       (done)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // One access, phase by phase. Returns at the falling edge inside T4.
   // chained: the call starts in T4 of the previous access (no leading edge).
   task automatic run_cycle(input logic [23:0] a, input bit wr, input bit hb,
                            input logic [15:0] wd, input logic [3:0] rs,
                            input int nw, input logic [15:0] rv,
                            input logic [3:0] exp_st, input bit chained,
                            input bit poke);
      if (!chained) @(negedge clk);
      chk("R11 ready before start", 32'(req_ready), 32'd1);
      req_addr = a; req_write = wr; req_hibyte = hb; req_wdata = wd;
      req_reason = rs; req_valid = 1'b1;
      @(negedge clk);                                   // T1
      req_valid = 1'b0;
      bus_ad_in = rv;
      chk("R2 strobe low in T1", 32'(addr_stb_n), 32'd0);
      chk("R2 latch enable low in T1", 32'(latch_en), 32'd0);
      chk("R2 low address on shared lines", 32'(bus_ad_out), 32'(a[15:0]));
      chk("R2 shared lines driven in T1", 32'(bus_ad_oe), 32'd1);
      chk("R2 upper address in T1", 32'(bus_a_hi), 32'(a[23:16]));
      chk("R3 direction in T1", 32'(xfer_rd), 32'(!wr));
      chk("R3 upper byte enable in T1", 32'(hi_byte_n), 32'(!hb));
      chk("R8 R9 status in T1", 32'(cyc_status), 32'(exp_st));
      chk("R11 not ready in T1", 32'(req_ready), 32'd0);
      chk("R7 read data held", 32'(rd_data), 32'(exp_rd));
      @(negedge clk);                                   // T2
      chk("R2 strobe back high in T2", 32'(addr_stb_n), 32'd1);
      chk("R4 drive enable in T2", 32'(bus_ad_oe), 32'(wr));
      if (wr) chk("R4 write data in T2", 32'(bus_ad_out), 32'(wd));
      chk("R4 upper address in T2", 32'(bus_a_hi), 32'(a[23:16]));
      chk("R5 no done in T2", 32'(done), 32'd0);
      if (poke) begin
         req_addr = ~a; req_write = ~wr; req_valid = 1'b1;
      end
      @(negedge clk);                                   // T3
      if (poke) begin
         chk("R11 busy request ignored strobe", 32'(addr_stb_n), 32'd1);
         chk("R11 busy request ignored address", 32'(bus_a_hi), 32'(a[23:16]));
         chk("R11 busy request ignored direction", 32'(xfer_rd), 32'(!wr));
         req_valid = 1'b0; req_addr = a; req_write = wr;
      end
      chk("R4 drive enable in T3", 32'(bus_ad_oe), 32'(wr));
      chk("R5 no done in T3", 32'(done), 32'd0);
      bus_wait = (nw > 0);
      for (int i = 0; i < nw; i++) begin
         @(negedge clk);                                // wait state i
         chk("R6 no done in wait state", 32'(done), 32'd0);
         chk("R4 upper address in wait state", 32'(bus_a_hi), 32'(a[23:16]));
         chk("R3 direction in wait state", 32'(xfer_rd), 32'(!wr));
         bus_wait = (i + 1 < nw);
      end
      @(negedge clk);                                   // T4, clock 4+nw
      bus_wait = 1'b0;
      chk("R5 R6 done in clock 4+N", 32'(done), 32'd1);
      chk("R3 upper byte enable in T4", 32'(hi_byte_n), 32'(!hb));
      chk("R8 R9 status in T4", 32'(cyc_status), 32'(exp_st));
      chk("R11 ready in T4", 32'(req_ready), 32'd1);
      if (!wr) exp_rd = rv;
   endtask

   task automatic idle_after(input string tag);
      @(negedge clk);
      chk({tag, " idle: no done"}, 32'(done), 32'd0);
      chk({tag, " idle: strobe high"}, 32'(addr_stb_n), 32'd1);
      chk({tag, " idle: R7 read data"}, 32'(rd_data), 32'(exp_rd));
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 strobe", 32'(addr_stb_n), 32'd1);
      chk("R1 latch enable", 32'(latch_en), 32'd1);
      chk("R1 drive enable", 32'(bus_ad_oe), 32'd0);
      chk("R1 done", 32'(done), 32'd0);
      chk("R1 direction", 32'(xfer_rd), 32'd0);
      chk("R1 upper byte", 32'(hi_byte_n), 32'd1);
      chk("R1 upper address", 32'(bus_a_hi), 32'd0);
      chk("R1 read data", 32'(rd_data), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 R11 ready after reset", 32'(req_ready), 32'd1);
   endtask

   task automatic t_read_nowait;     // R5 R7 R8: sequential fetch
      run_cycle(24'hA51234, 1'b0, 1'b1, 16'h0000, 4'b1000, 0, 16'hBEEF,
                4'b1000, 1'b0, 1'b0);
      idle_after("R7 read");
   endtask

   task automatic t_write_wait;      // R4 R6 R7: write with 3 wait states
      run_cycle(24'h3C00FE, 1'b1, 1'b0, 16'h5AA5, 4'b1010, 3, 16'h1111,
                4'b1010, 1'b0, 1'b0);
      idle_after("R7 write keeps");
   endtask

   task automatic t_rmw;             // R9
      run_cycle(24'h001000, 1'b0, 1'b1, 16'h0000, 4'b1011, 0, 16'h7E7E,
                4'b1011, 1'b0, 1'b0);
      run_cycle(24'h001000, 1'b1, 1'b1, 16'h7E7F, 4'b1011, 1, 16'h0000,
                4'b1010, 1'b1, 1'b0);
      idle_after("R9 rmw");
   endtask

   task automatic t_idle_codes;      // R10
      logic [3:0] codes [6] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h5, 4'hF};
      logic [3:0] expv  [6] = '{4'h0, 4'h1, 4'h3, 4'h0, 4'h0, 4'h0};
      for (int i = 0; i < 6; i++) begin
         idle_code = codes[i];
         #2;
         chk("R10 idle status", 32'(cyc_status), 32'(expv[i]));
      end
      idle_code = 4'h1;
   endtask

   task automatic t_back_to_back;    // R11 R8 R7: chained accesses
      run_cycle(24'hFF0002, 1'b0, 1'b0, 16'h0000, 4'b0100, 0, 16'hC0DE,
                4'b0100, 1'b0, 1'b0);
      run_cycle(24'h80FFFF, 1'b0, 1'b1, 16'h0000, 4'b1001, 2, 16'h0F0F,
                4'b1001, 1'b1, 1'b0);
      run_cycle(24'h7F0001, 1'b1, 1'b1, 16'hFFFF, 4'b0110, 0, 16'h0000,
                4'b0110, 1'b1, 1'b0);
      idle_after("R11 chain");
   endtask

   task automatic t_ignored_req;     // R11: request while busy
      run_cycle(24'h12ABCD, 1'b0, 1'b0, 16'h0000, 4'b1100, 1, 16'h4242,
                4'b1100, 1'b0, 1'b1);
      idle_after("R11 ignored");
      chk("R11 no extra access", 32'(req_ready), 32'd1);
   endtask

   initial begin
      t_reset();
      t_read_nowait();
      t_write_wait();
      t_rmw();
      t_idle_codes();
      t_back_to_back();
      t_ignored_req();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not end, actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule